// File: doc/BRIEF.md
# Eight-bit ALU with processor flags

This block is the arithmetic and logic unit of a small accumulator-style processor. Each beat carries one operation: two operands (the accumulator value `A` and a memory or register value `B`), the current carry flag and a 4-bit operation code. The block returns the result, a result write-enable, new values for the carry (C), zero (Z), overflow (V) and negative (N) flags, and one write-enable per flag. The surrounding core applies only the flags whose enable is set. Decimal arithmetic is not supported. The decimal flag lives outside this block and does not change how add or subtract behave.

The arithmetic is combinational. One output register stage sits in front of a valid/ready stream. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high from the next cycle on. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output stage holds its beat unchanged and `in_ready` is low, so back-pressure reaches the producer in the same cycle.

Top module: `alu8_core`

## Requirements
- R1: Add with carry (op 0): the result is (A+B+Cin) mod 2^W. C is set when the true sum exceeds 2^W-1. V is set when A and B have the same sign bit and the result's sign bit differs from A's. All four flags are enabled.
- R2: Subtract with borrow (op 1): the result is A-B-(1-Cin) mod 2^W. C is set when the true difference is zero or positive. V is set when A and B differ in sign and the result's sign differs from A's. All four flags are enabled.
- R3: Compare (op 5): Z and N come from (A-B) mod 2^W, and C is set when A >= B as unsigned numbers. V is not enabled. The result write-enable is low.
- R4: Bit test (op 6): Z is set when A AND B is zero, N is B's top bit and V is B's next-lower bit. C is not enabled. The result write-enable is low.
- R5: Left shift (op 9) moves A's top bit into C and shifts in a zero. Right shift (op 10) moves A's bit 0 into C and shifts in a zero at the top.
- R6: Rotate left (op 11) moves A's top bit into C and puts Cin into bit 0. Rotate right (op 12) moves A's bit 0 into C and puts Cin into the top bit.
- R7: Increment (op 7) and decrement (op 8) act on A and wrap modulo 2^W. Only Z and N are enabled.
- R8: AND (op 2), OR (op 3), XOR (op 4) of A and B, and pass-through of B (op 13, for loads and transfers), write the result. Z is set when the result is zero and N is the result's top bit. C and V are not enabled.
- R9: Every flag output whose enable is low is driven to 0, and the result output is 0 whenever the result write-enable is low. Codes 14 and 15 enable nothing.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. An accepted beat appears at the output exactly one cycle later. A beat stalled by a low `out_ready` keeps all output fields stable.
- R11: While reset is asserted and after it is released, `out_valid` is low until the first beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | DATA_W | Accumulator operand |
| in_b | input | DATA_W | Second operand |
| in_cin | input | 1 | Current carry flag |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_res | output | DATA_W | Result |
| out_res_we | output | 1 | Result should be written back |
| out_c | output | 1 | New carry flag |
| out_z | output | 1 | New zero flag |
| out_v | output | 1 | New overflow flag |
| out_n | output | 1 | New negative flag |
| out_we_c | output | 1 | Carry flag write-enable |
| out_we_z | output | 1 | Zero flag write-enable |
| out_we_v | output | 1 | Overflow flag write-enable |
| out_we_n | output | 1 | Negative flag write-enable |

## Verification
The bench builds the block with the default `DATA_W` of 8. At that width the sign boundary at 0x7F/0x80 and the carry boundary at 0xFF/0x00 are reached directly by the directed cases and often by random operands. A behavioural model works out every flag from integer arithmetic and is compared with the outputs on every clock. An early phase keeps `out_ready` high. A later phase toggles `out_ready` and inserts gaps in `in_valid`, so stalled beats and back-to-back acceptance both occur many times.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADC  = 4'd0,
    OP_SBC  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_ASL  = 4'd9,
    OP_LSR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_PASS = 4'd13
  } alu_op_e;

  // which flags an operation is allowed to change
  typedef struct packed {
    logic c;
    logic z;
    logic v;
    logic n;
  } flag_set_t;

  function automatic flag_set_t flag_mask(alu_op_e op);
    flag_set_t m;
    m = '0;
    case (op)
      OP_ADC, OP_SBC:                     m = '{c: 1'b1, z: 1'b1, v: 1'b1, n: 1'b1};
      OP_CMP, OP_ASL, OP_LSR,
      OP_ROL, OP_ROR:                     m = '{c: 1'b1, z: 1'b1, v: 1'b0, n: 1'b1};
      OP_BIT:                             m = '{c: 1'b0, z: 1'b1, v: 1'b1, n: 1'b1};
      OP_AND, OP_OR, OP_XOR, OP_PASS,
      OP_INC, OP_DEC:                     m = '{c: 1'b0, z: 1'b1, v: 1'b0, n: 1'b1};
      default:                            m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   wide;

  // one adder serves all five arithmetic codes; subtraction is A + ~B + carry
  always_comb begin
    case (op)
      OP_ADC:  begin b_eff = b;        c_eff = cin;  end
      OP_SBC:  begin b_eff = ~b;       c_eff = cin;  end
      OP_CMP:  begin b_eff = ~b;       c_eff = 1'b1; end
      OP_INC:  begin b_eff = '0;       c_eff = 1'b1; end
      OP_DEC:  begin b_eff = '1;       c_eff = 1'b0; end
      default: begin b_eff = b;        c_eff = 1'b0; end
    endcase
  end

  assign wide = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
  assign sum  = wide[MSB:0];
  assign cout = wide[DATA_W];
  // operands of the adder agree in sign but the sum disagrees
  assign ovf  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND, OP_BIT: res = a & b;
      OP_OR:          res = a | b;
      OP_XOR:         res = a ^ b;
      OP_PASS:        res = b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int MSB = DATA_W - 1;

  logic fill;
  logic left;

  always_comb begin
    left = (op == OP_ASL) || (op == OP_ROL);
    fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;
  end

  always_comb begin
    if (left) begin
      res  = {a[MSB-1:0], fill};
      cout = a[MSB];
    end else begin
      res  = {fill, a[MSB:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_cin,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_res,
  output logic              out_res_we,
  output logic              out_c,
  output logic              out_z,
  output logic              out_v,
  output logic              out_n,
  output logic              out_we_c,
  output logic              out_we_z,
  output logic              out_we_v,
  output logic              out_we_n
);
  localparam int MSB = DATA_W - 1;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  logic [DATA_W-1:0] as_sum, lg_res, sh_res;
  logic              as_c, as_v, sh_c;

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(op), .a(in_a), .b(in_b), .cin(in_cin),
    .sum(as_sum), .cout(as_c), .ovf(as_v)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op), .a(in_a), .b(in_b), .res(lg_res)
  );

  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .op(op), .a(in_a), .cin(in_cin), .res(sh_res), .cout(sh_c)
  );

  // select the source for result and flags
  flag_set_t         mask;
  logic [DATA_W-1:0] zn_src;
  logic [DATA_W-1:0] nx_res;
  logic              nx_res_we;
  logic              raw_c, raw_v, raw_n, raw_z;

  always_comb begin
    mask      = flag_mask(op);
    nx_res_we = 1'b0;
    zn_src    = '0;
    raw_c     = 1'b0;
    raw_v     = 1'b0;
    case (op)
      OP_ADC, OP_SBC: begin
        zn_src = as_sum; raw_c = as_c; raw_v = as_v; nx_res_we = 1'b1;
      end
      OP_CMP: begin
        zn_src = as_sum; raw_c = as_c;
      end
      OP_INC, OP_DEC: begin
        zn_src = as_sum; nx_res_we = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS: begin
        zn_src = lg_res; nx_res_we = 1'b1;
      end
      OP_BIT: begin
        zn_src = lg_res; raw_v = in_b[MSB-1];
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        zn_src = sh_res; raw_c = sh_c; nx_res_we = 1'b1;
      end
      default: ;
    endcase
    raw_z  = (zn_src == '0);
    // bit test takes N from the operand, not from the AND
    raw_n  = (op == OP_BIT) ? in_b[MSB] : zn_src[MSB];
    nx_res = nx_res_we ? zn_src : '0;
  end

  // output stage
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_res    <= nx_res;
      out_res_we <= nx_res_we;
      out_c      <= raw_c & mask.c;
      out_z      <= raw_z & mask.z;
      out_v      <= raw_v & mask.v;
      out_n      <= raw_n & mask.n;
      out_we_c   <= mask.c;
      out_we_z   <= mask.z;
      out_we_v   <= mask.v;
      out_we_n   <= mask.n;
    end
  end

  // checks kept beside the stage they guard
  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_c)
      && $stable(out_z) && $stable(out_v) && $stable(out_n) && $stable(out_res_we)));

  p_adc_carry_r1: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 4'd0) |=>
      out_c == (({1'b0, $past(in_a)} + {1'b0, $past(in_b)} + {{DATA_W{1'b0}}, $past(in_cin)}) > {1'b0, {DATA_W{1'b1}}}));

  p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 4'd5) |=> (!out_res_we && out_we_c && !out_we_v
      && out_c == ($past(in_a) >= $past(in_b))));

  p_bit_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == 4'd6) |=> (out_n == $past(in_b[MSB]) && out_v == $past(in_b[MSB-1])
      && !out_we_c && !out_res_we));

  p_incdec_only_zn_r7: assert property (@(posedge clk) disable iff (rst)
    (take && (in_op == 4'd7 || in_op == 4'd8)) |=> (!out_we_c && !out_we_v && out_we_z && out_we_n));

  p_masked_zero_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_we_c || !out_c) && (out_we_z || !out_z) && (out_we_v || !out_v)
      && (out_we_n || !out_n) && (out_res_we || out_res == '0)));

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_cin = 1'b0;
  logic [3:0] in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_res;
  logic out_res_we, out_c, out_z, out_v, out_n, out_we_c, out_we_z, out_we_v, out_we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_res_we(out_res_we), .out_c(out_c), .out_z(out_z), .out_v(out_v),
    .out_n(out_n), .out_we_c(out_we_c), .out_we_z(out_we_z),
    .out_we_v(out_we_v), .out_we_n(out_we_n)
  );

  typedef struct packed {
    logic [W-1:0] res;
    logic rwe, c, z, v, n, wc, wz, wv, wn;
  } exp_t;

  int n_checks = 0;
  int n_fail = 0;

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      5: return "R3";
      6: return "R4";
      9, 10: return "R5";
      11, 12: return "R6";
      7, 8: return "R7";
      2, 3, 4, 13: return "R8";
      default: return "R9";
    endcase
  endfunction

  // behavioural reference from the requirement text
  function automatic exp_t model(int op, int a, int b, int ci);
    exp_t e;
    int r, t;
    bit wr;
    e = '0;
    r = 0; wr = 0;
    case (op)
      0: begin t = a + b + ci; r = t % 256; wr = 1;
         e.c = t > 255; e.v = (((a ^ b) & 128) == 0) && (((a ^ r) & 128) != 0);
         e.wc = 1; e.wz = 1; e.wv = 1; e.wn = 1; end
      1: begin t = a - b - (1 - ci); r = (t + 512) % 256; wr = 1;
         e.c = t >= 0; e.v = (((a ^ b) & 128) != 0) && (((a ^ r) & 128) != 0);
         e.wc = 1; e.wz = 1; e.wv = 1; e.wn = 1; end
      2: begin r = a & b; wr = 1; e.wz = 1; e.wn = 1; end
      3: begin r = a | b; wr = 1; e.wz = 1; e.wn = 1; end
      4: begin r = a ^ b; wr = 1; e.wz = 1; e.wn = 1; end
      13: begin r = b; wr = 1; e.wz = 1; e.wn = 1; end
      5: begin t = (a - b + 256) % 256; e.c = a >= b; e.z = t == 0; e.n = t >= 128;
         e.wc = 1; e.wz = 1; e.wn = 1; end
      6: begin e.z = (a & b) == 0; e.n = (b >> 7) & 1; e.v = (b >> 6) & 1;
         e.wz = 1; e.wv = 1; e.wn = 1; end
      7: begin r = (a + 1) % 256; wr = 1; e.wz = 1; e.wn = 1; end
      8: begin r = (a + 255) % 256; wr = 1; e.wz = 1; e.wn = 1; end
      9: begin r = (a * 2) % 256; e.c = a >= 128; wr = 1; e.wc = 1; e.wz = 1; e.wn = 1; end
      10: begin r = a / 2; e.c = a % 2; wr = 1; e.wc = 1; e.wz = 1; e.wn = 1; end
      11: begin r = (a * 2) % 256 + ci; e.c = a >= 128; wr = 1; e.wc = 1; e.wz = 1; e.wn = 1; end
      12: begin r = a / 2 + ci * 128; e.c = a % 2; wr = 1; e.wc = 1; e.wz = 1; e.wn = 1; end
      default: ;
    endcase
    if (wr) begin
      e.res = r[W-1:0]; e.rwe = 1; e.z = r == 0; e.n = r >= 128;
    end
    return e;
  endfunction

  // cycle model of the output stage
  logic mv = 1'b0;
  exp_t me = '0;
  string mtag = "R11";

  always @(posedge clk) begin
    if (rst) mv <= 1'b0;
    else if (!mv || out_ready) begin
      mv <= in_valid;
      if (in_valid) begin
        me <= model(int'(in_op), int'(in_a), int'(in_b), int'(in_cin));
        mtag <= tag_of(int'(in_op));
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    exp_t got;
    check(in_ready == (!mv || out_ready), "R10", "in_ready", in_ready, !mv || out_ready);
    check(out_valid == mv, "R10", "out_valid", out_valid, mv);
    if (mv && out_valid) begin
      got = {out_res, out_res_we, out_c, out_z, out_v, out_n, out_we_c, out_we_z, out_we_v, out_we_n};
      check(got == me, mtag, "beat {res,rwe,c,z,v,n,wc,wz,wv,wn}", got, me);
    end
  endtask

  // stimulus queue: {op, a, b, cin}
  typedef struct packed { logic [3:0] op; logic [W-1:0] a, b; logic ci; } stim_t;
  stim_t q[$];

  task automatic push(int op, int a, int b, int ci);
    stim_t s;
    s.op = op[3:0]; s.a = a[W-1:0]; s.b = b[W-1:0]; s.ci = ci[0];
    q.push_back(s);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_checks++; n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run_queue(bit stress);
    while (q.size() > 0) begin
      @(negedge clk);
      compare_now();
      out_ready = stress ? ($urandom_range(0, 2) != 0) : 1'b1;
      in_valid  = stress ? ($urandom_range(0, 3) != 0) : 1'b1;
      in_op = q[0].op; in_a = q[0].a; in_b = q[0].b; in_cin = q[0].ci;
      #1;
      if (in_valid && in_ready) void'(q.pop_front());
    end
    @(negedge clk);
    compare_now();
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) begin
      @(negedge clk);
      compare_now();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);

    // R1 corners
    push(0, 8'h7F, 8'h01, 0); push(0, 8'hFF, 8'h01, 0); push(0, 8'h80, 8'h80, 1);
    push(0, 8'h10, 8'h20, 1);
    // R2 corners
    push(1, 8'h00, 8'h01, 1); push(1, 8'h80, 8'h01, 1); push(1, 8'h05, 8'h05, 0);
    push(1, 8'h7F, 8'hFF, 1);
    // R3 compare
    push(5, 8'h40, 8'h40, 0); push(5, 8'h10, 8'h20, 1); push(5, 8'hFF, 8'h00, 0);
    // R4 bit test
    push(6, 8'h3F, 8'hC0, 1); push(6, 8'hFF, 8'h41, 0); push(6, 8'h01, 8'h00, 0);
    // R5 and R6 shifts and rotates
    push(9, 8'h81, 0, 1); push(10, 8'h81, 0, 1); push(11, 8'h81, 0, 1);
    push(12, 8'h81, 0, 1); push(11, 8'h00, 0, 0); push(12, 8'h01, 0, 0);
    // R7 wrap
    push(7, 8'hFF, 0, 1); push(8, 8'h00, 0, 1); push(8, 8'h01, 0, 0);
    // R8 logic and pass
    push(2, 8'hF0, 8'h0F, 1); push(3, 8'h80, 8'h01, 0); push(4, 8'hAA, 8'hAA, 1);
    push(13, 8'h12, 8'h00, 1);
    // R9 unused codes
    push(14, 8'h55, 8'h55, 1); push(15, 8'hFF, 8'hFF, 1);
    run_queue(1'b0);

    for (int i = 0; i < 800; i++)
      push($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1));
    run_queue(1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule